// File: doc/BRIEF.md
# SPI Serial Shift Engine

This block is the serial half of an SPI port. It takes one transmit word at a time through a valid/ready handshake and holds it in a single holding register. It moves the word into a shift register and clocks it out MSB first. At the same time it assembles the incoming bits into a received word, which it presents with a one-cycle strobe. The same engine runs as bus master, generating the serial clock from the module clock, or as a slave that follows an external serial clock and chip select. In slave mode those external signals are brought into the module clock domain by synchronizers first.

Configuration inputs select the word length (8, 16, 32 bits, or a 9-bit master format whose leading bit comes from a configuration input), the clock polarity and phase, and the master clock divider. Other inputs control the data-out level while the line is idle, and can hold that line at a static level. A synchronized copy of the data-in pin is always available. In master mode, clearing the enable lets the words already accepted finish before the engine resets itself. A soft-reset input clears the engine at once.

Top module: `spi_shift_engine`

## Requirements
- R1: Word-size code 00, 01 and 10 select 8, 16 and 32 bits. The word is sent MSB first from the low bits of the transmit word. The received bits fill the low bits of the received word in arrival order, with the last bit in bit 0.
- R2: Code 11 in master mode sends 9 bits: first `ninth_bit_i`, then bits 7..0 of the transmit word. Only the last 8 received bits reach received bits 7..0. In slave mode, code 11 behaves as code 00.
- R3: In master mode one serial clock period lasts 8, 4, 2 or 14 module clock cycles for divider code 00, 01, 10 or 11.
- R4: While no word is in progress, `sclk_o` equals `cpol_i`. With `cpha_i`=0, data is set up before the leading edge and sampled on the leading edge. With `cpha_i`=1, data changes on the leading edge and is sampled on the trailing edge.
- R5: While no word is in progress, `do_o` equals `idle_do_i`. While `force_do_i`=1, `do_o` equals `idle_do_i` at all times, even during a transfer.
- R6: `din_sync_o` equals the value `di_i` had two module clock edges earlier.
- R7: In slave mode with `cs_en_i`=1, a word is shifted only while `cs_ni` is low. With `cs_en_i`=0, `cs_ni` is ignored and the slave is always selected.
- R8: There is one holding register. A word is taken when `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is high only when `en_i`=1, `soft_rst_i`=0 and the holding register is empty. Consecutive words are sent in order.
- R9: When `en_i` falls in master mode, the word being shifted and the held word both complete. After that the engine goes idle and `rx_data_o` reads 0. In slave mode, clearing `en_i` clears the engine at once.
- R10: `soft_rst_i`=1 discards the word in progress and the held word, and clears `rx_data_o` to 0 on the next edge. No receive strobe follows. `din_sync_o` keeps tracking `di_i`.
- R11: In 8-bit and 9-bit formats, received bits 31..8 keep their previous value. In 16-bit format, bits 31..16 keep their previous value.
- R12: `rx_valid_o` is high for exactly one module clock per word. It rises on the first module clock edge after the last bit of the word is sampled, and `rx_data_o` holds the new word in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| soft_rst_i | input | 1 | Synchronous engine clear |
| slave_i | input | 1 | 0 master, 1 slave |
| cpol_i | input | 1 | Idle serial clock level |
| cpha_i | input | 1 | Sampling edge select |
| word_sel_i | input | 2 | Word format code |
| clk_sel_i | input | 2 | Master divider code |
| ninth_bit_i | input | 1 | Leading bit of the 9-bit format |
| idle_do_i | input | 1 | Idle / forced data-out level |
| force_do_i | input | 1 | Hold data-out at idle level |
| cs_en_i | input | 1 | Honour chip select in slave mode |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register can accept |
| rx_data_o | output | 32 | Received word |
| rx_valid_o | output | 1 | Received word strobe |
| busy_o | output | 1 | Word in progress |
| din_sync_o | output | 1 | Synchronized data-in |
| sclk_o | output | 1 | Master serial clock |
| do_o | output | 1 | Serial data out |
| sclk_i | input | 1 | Slave serial clock |
| cs_ni | input | 1 | Slave chip select, active low |
| di_i | input | 1 | Serial data in |

## Verification
The case of interest is a forced data-out level during an active master transfer. Shifting and forcing then both act on `do_o` in the same cycles. The bench provokes this by looping `do_o` back to `di_i` and sending words whose bits are the opposite of the forced level. On every clock, the reference model requires `do_o` to stay at the forced level. It also requires each received word to be all copies of that level, while the serial clock keeps its divider period. The other overlap is the end of a drain: the last receive strobe and the clear that follows fall on neighbouring edges. The bench checks that word's data in its strobe cycle, and checks for zero afterwards.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = 3;
  localparam int NB_W   = $clog2(DATA_W) + 1;
  localparam int CNT_W  = $clog2(2 * DATA_W);

  typedef enum logic [1:0] {
    FMT_8  = 2'b00,
    FMT_16 = 2'b01,
    FMT_32 = 2'b10,
    FMT_9  = 2'b11
  } word_fmt_e;

  function automatic logic [NB_W-1:0] word_bits(input logic [1:0] sel, input logic slave);
    case (word_fmt_e'(sel))
      FMT_16:  return NB_W'(16);
      FMT_32:  return NB_W'(32);
      FMT_9:   return slave ? NB_W'(8) : NB_W'(9);
      default: return NB_W'(8);
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
    case (sel)
      2'b00:   return HALF_W'(4);
      2'b01:   return HALF_W'(2);
      2'b10:   return HALF_W'(1);
      default: return HALF_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
  import spi_eng_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;

  assign half   = half_period(sel_i);
  assign tick_o = run_i && (cnt_q == half - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + HALF_W'(1);
  end

  // R3: a half period longer than one cycle never yields adjacent ticks
  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half != HALF_W'(1) && $stable(sel_i)) |=> !tick_o);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_ok_i,
  input  logic              slave_i,
  input  logic              active_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [1:0]        word_sel_i,
  input  logic              ninth_bit_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              tick_i,
  input  logic              sclk_s_i,
  input  logic              din_i,
  output logic              sclk_o,
  output logic              line_o,
  output logic              busy_o,
  output logic              hold_full_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic              run_q, hold_full_q, sclk_q, sclk_prev_q, rx_valid_q;
  logic [DATA_W-1:0] hold_q, sh_q, rx_sh_q, rx_q;
  logic [DATA_W-1:0] aligned, rx_sh_nxt, merged;
  logic [CNT_W-1:0]  edge_q;
  logic [NB_W-1:0]   nbits_q;
  logic accept, load, abort, edge_evt, lead, sample_evt, shift_evt, last;

  assign tx_ready_o = accept_ok_i && !hold_full_q;
  assign accept     = tx_valid_i && tx_ready_o;
  assign load       = !run_q && hold_full_q && (!slave_i || active_i);
  assign abort      = slave_i && !active_i;

  assign edge_evt   = run_q && (slave_i ? (sclk_s_i ^ sclk_prev_q) : tick_i);
  assign lead       = !edge_q[0];
  assign last       = ({1'b0, edge_q} == ({nbits_q, 1'b0} - (NB_W+1)'(1)));
  assign sample_evt = edge_evt && (lead ^ cpha_i);
  // first leading edge with cpha=1 and last trailing edge with cpha=0 move nothing
  assign shift_evt  = edge_evt && !(lead ^ cpha_i) &&
                      !(cpha_i ? (edge_q == '0) : last);
  assign rx_sh_nxt  = sample_evt ? {rx_sh_q[DATA_W-2:0], din_i} : rx_sh_q;

  always_comb begin
    case (word_fmt_e'(word_sel_i))
      FMT_16:  aligned = {hold_q[15:0], 16'b0};
      FMT_32:  aligned = hold_q;
      FMT_9:   aligned = slave_i ? {hold_q[7:0], 24'b0}
                                 : {ninth_bit_i, hold_q[7:0], 23'b0};
      default: aligned = {hold_q[7:0], 24'b0};
    endcase
  end

  always_comb begin
    case (nbits_q)
      NB_W'(32): merged = rx_sh_nxt;
      NB_W'(16): merged = {rx_q[31:16], rx_sh_nxt[15:0]};
      default:   merged = {rx_q[31:8], rx_sh_nxt[7:0]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; hold_full_q <= 1'b0; hold_q <= '0; sh_q <= '0;
      rx_sh_q <= '0; rx_q <= '0; rx_valid_q <= 1'b0; edge_q <= '0;
      nbits_q <= NB_W'(8); sclk_q <= 1'b0; sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      rx_valid_q  <= 1'b0;
      if (clear_i) begin
        run_q <= 1'b0; hold_full_q <= 1'b0; rx_q <= '0;
        edge_q <= '0; sclk_q <= cpol_i;
      end else begin
        if (accept) begin
          hold_q      <= tx_data_i;
          hold_full_q <= 1'b1;
        end
        if (load) begin
          hold_full_q <= 1'b0;
          sh_q        <= aligned;
          nbits_q     <= word_bits(word_sel_i, slave_i);
          edge_q      <= '0;
          sclk_q      <= cpol_i;
          rx_sh_q     <= '0;
          run_q       <= 1'b1;
        end else if (run_q) begin
          if (abort) run_q <= 1'b0;
          else if (edge_evt) begin
            sclk_q  <= ~sclk_q;
            rx_sh_q <= rx_sh_nxt;
            if (shift_evt) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            if (last) begin
              run_q      <= 1'b0;
              rx_valid_q <= 1'b1;
              rx_q       <= merged;
            end else edge_q <= edge_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sclk_o      = sclk_q;
  assign line_o      = sh_q[DATA_W-1];
  assign busy_o      = run_q;
  assign hold_full_o = hold_full_q;
  assign rx_data_o   = rx_q;
  assign rx_valid_o  = rx_valid_q;

  a_r8_single_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !tx_ready_o);
  a_r12_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r11_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && nbits_q <= NB_W'(9)) |-> rx_data_o[31:8] == $past(rx_data_o[31:8]));
  a_r10_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!busy_o && !hold_full_o && rx_data_o == '0 && !rx_valid_o));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              soft_rst_i,
  input  logic              slave_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [1:0]        word_sel_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              ninth_bit_i,
  input  logic              idle_do_i,
  input  logic              force_do_i,
  input  logic              cs_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              din_sync_o,
  output logic              sclk_o,
  output logic              do_o,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              di_i
);
  localparam int         N_LANES  = 3;
  localparam logic [2:0] LANE_RST = 3'b100;  // chip select idles high

  logic [N_LANES-1:0] pin_raw, pin_sync;
  logic busy, hold_full, tick, sclk_raw, line, active, clear, din_sel;

  assign pin_raw = {cs_ni, sclk_i, di_i};

  for (genvar g = 0; g < N_LANES; g++) begin : g_sync
    spi_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LANE_RST[g])) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_raw[g]), .q_o(pin_sync[g])
    );
  end

  assign din_sync_o = pin_sync[0];
  assign active     = !cs_en_i || !pin_sync[2];
  assign din_sel    = slave_i ? pin_sync[0] : di_i;
  // master drains accepted words before clearing; slave clears at once
  assign clear      = soft_rst_i || (!en_i && (slave_i || (!busy && !hold_full)));

  spi_half_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy && !slave_i),
    .sel_i(clk_sel_i), .tick_o(tick)
  );

  spi_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
    .accept_ok_i(en_i && !soft_rst_i), .slave_i(slave_i), .active_i(active),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .word_sel_i(word_sel_i),
    .ninth_bit_i(ninth_bit_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tick_i(tick), .sclk_s_i(pin_sync[1]),
    .din_i(din_sel), .sclk_o(sclk_raw), .line_o(line), .busy_o(busy),
    .hold_full_o(hold_full), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  assign busy_o = busy;
  assign sclk_o = (!slave_i && busy) ? sclk_raw : cpol_i;
  assign do_o   = (force_do_i || !busy) ? idle_do_i : line;
endmodule

// File: tb/tb_spi_shift_engine.sv
module tb_spi_shift_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int SHALF      = 6;

  logic clk = 0, rst_ni = 0;
  logic en = 0, soft_rst = 0, slave = 0, cpol = 0, cpha = 0, ninth = 0;
  logic idle_do = 0, force_do = 0, cs_en = 0, tx_valid = 0;
  logic [1:0] word_sel = 0, clk_sel = 0;
  logic [31:0] tx_data = 0;
  logic sclk_in = 0, cs_n = 1, di_drv = 0, loop = 0;
  logic tx_ready, rx_valid, busy, din_sync, sclk, dout, di;
  logic [31:0] rx_data;

  assign di = loop ? dout : di_drv;

  spi_shift_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .soft_rst_i(soft_rst), .slave_i(slave),
    .cpol_i(cpol), .cpha_i(cpha), .word_sel_i(word_sel), .clk_sel_i(clk_sel),
    .ninth_bit_i(ninth), .idle_do_i(idle_do), .force_do_i(force_do), .cs_en_i(cs_en),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .busy_o(busy), .din_sync_o(din_sync),
    .sclk_o(sclk), .do_o(dout), .sclk_i(sclk_in), .cs_ni(cs_n), .di_i(di)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] exp_rx_q[$], exp_line_q[$];
  int exp_n_q[$];
  logic [31:0] mrx = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  // two-edge history of di
  logic h1 = 0, h2 = 0;
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) begin h1 <= 0; h2 <= 0; end
    else begin h1 <= di; h2 <= h1; end

  // behavioural reference compared every clock
  logic p_sclk = 0, p_do = 0, p_busy = 0, p_rxv = 0, have_rise = 0;
  logic [31:0] line_bits = 0;
  int line_n = 0, last_rise = 0;

  function automatic int div_of(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 4; 2'd2: return 2; default: return 14; endcase
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(din_sync == h2, "R6 din_sync", {31'b0, din_sync}, {31'b0, h2});
      if (!busy) chk(sclk == cpol, "R4 idle sclk", {31'b0, sclk}, {31'b0, cpol});
      if (!busy || force_do) chk(dout == idle_do, "R5 idle/forced do", {31'b0, dout}, {31'b0, idle_do});
      if (!slave && (busy || p_busy) && sclk != p_sclk) begin
        bit is_lead;
        is_lead = (sclk != cpol);
        if (is_lead ^ cpha) begin
          line_bits = {line_bits[30:0], p_do};
          line_n++;
        end
      end
      if (!slave && busy && sclk && !p_sclk) begin
        if (have_rise) chk(cyc - last_rise == div_of(clk_sel), "R3 sclk period",
                           cyc - last_rise, div_of(clk_sel));
        have_rise = 1; last_rise = cyc;
      end
      if (!busy) have_rise = 0;
      if (rx_valid && p_rxv) chk(0, "R12 strobe width", 2, 1);
      if (rx_valid) begin
        if (exp_rx_q.size() == 0) chk(0, "R12 unexpected strobe", rx_data, 0);
        else begin
          logic [31:0] er, el, msk;
          int n;
          er = exp_rx_q.pop_front(); el = exp_line_q.pop_front(); n = exp_n_q.pop_front();
          chk(rx_data == er, "R1 R11 received word", rx_data, er);
          if (n > 0) begin
            msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
            chk(line_n == n, "R4 sample count", line_n, n);
            chk((line_bits & msk) == el, "R2 R4 line bits", line_bits & msk, el);
          end
        end
        line_n = 0; line_bits = 0;
      end
    end
    p_sclk = sclk; p_do = dout; p_busy = busy; p_rxv = rx_valid;
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] prev, input logic [31:0] d);
    case (word_sel)
      2'b01:   return {prev[31:16], d[15:0]};
      2'b10:   return d;
      default: return {prev[31:8], d[7:0]};
    endcase
  endfunction

  // expected result of a master loopback word (or of a slave word when line_ok=0)
  task automatic expect_word(input logic [31:0] d, input bit line_ok);
    logic [31:0] ln, seen;
    int n;
    n  = (word_sel == 2'b01) ? 16 : (word_sel == 2'b10) ? 32 : (word_sel == 2'b11 && !slave) ? 9 : 8;
    ln = (n == 9) ? {23'b0, ninth, d[7:0]} : (n == 32) ? d : (d & ((32'd1 << n) - 1));
    if (force_do && line_ok) ln = idle_do ? ((n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1)) : 0;
    seen = line_ok ? ln : d;
    mrx = merge(mrx, seen);
    exp_rx_q.push_back(mrx);
    exp_line_q.push_back(ln);
    exp_n_q.push_back(line_ok ? n : 0);
  endtask

  task automatic send(input logic [31:0] w);
    logic r;
    tx_data = w; tx_valid = 1;
    while (1) begin
      r = tx_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    tx_valid = 0;
  endtask

  task automatic send_m(input logic [31:0] w);
    expect_word(w, 1);
    send(w);
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while ((exp_rx_q.size() != 0 || busy) && t < 6000) begin cycles(1); t++; end
    chk(t < 6000, "R12 completion", t, 0);
    cycles(2);
  endtask

  task automatic slave_xfer(input int n, input logic [31:0] mosi, input logic [31:0] miso, input bit use_cs);
    logic [31:0] got;
    got = 0;
    sclk_in = cpol;
    if (use_cs) cs_n = 0;
    cycles(SHALF);
    for (int i = n - 1; i >= 0; i--) begin
      if (!cpha) begin
        di_drv = mosi[i]; cycles(SHALF);
        got = {got[30:0], dout}; sclk_in = ~cpol; cycles(SHALF); sclk_in = cpol;
      end else begin
        sclk_in = ~cpol; di_drv = mosi[i]; cycles(SHALF);
        got = {got[30:0], dout}; sclk_in = cpol; cycles(SHALF);
      end
    end
    cycles(SHALF);
    cs_n = 1;
    chk(got == miso, "R7 slave data out", got, miso);
  endtask

  initial begin
    cycles(4);
    chk(busy == 0 && rx_valid == 0, "R12 reset strobe/busy", {busy, rx_valid}, 0);
    chk(rx_data == 0, "R10 reset rx", rx_data, 0);
    chk(tx_ready == 0, "R8 ready needs enable", tx_ready, 0);
    rst_ni = 1;
    cycles(3);
    chk(tx_ready == 0, "R8 ready low while disabled", tx_ready, 0);
    en = 1; loop = 1;
    cycles(1);
    chk(tx_ready == 1, "R8 ready when enabled", tx_ready, 1);

    // R1 / R11 formats, master loopback
    word_sel = 2'b10; send_m(32'hDEAD_BEEF); wait_idle();
    word_sel = 2'b00; send_m(32'h0000_00A5); wait_idle();
    chk(rx_data == 32'hDEAD_BEA5, "R11 upper bits in 8-bit", rx_data, 32'hDEAD_BEA5);
    word_sel = 2'b01; send_m(32'hFFFF_1234); wait_idle();
    chk(rx_data == 32'hDEAD_1234, "R11 upper bits in 16-bit", rx_data, 32'hDEAD_1234);
    // R2 nine-bit master
    word_sel = 2'b11; ninth = 1; send_m(32'h0000_003C); wait_idle();
    ninth = 0; send_m(32'h0000_00C3); wait_idle();
    chk(rx_data == 32'hDEAD_12C3, "R2 nine-bit receive", rx_data, 32'hDEAD_12C3);

    // R3 R4 every polarity, phase and divider
    word_sel = 2'b00;
    for (int m = 0; m < 16; m++) begin
      cpol = m[0]; cpha = m[1]; clk_sel = m[3:2];
      cycles(2);
      send_m(32'h5A ^ m);
      wait_idle();
    end
    cpol = 0; cpha = 0; clk_sel = 2'b10;

    // R8 back-to-back words through the holding register
    word_sel = 2'b01;
    send_m(32'h0000_A1B2); send_m(32'h0000_C3D4); send_m(32'h0000_E5F6);
    wait_idle();

    // R5 forced data-out during transfers
    force_do = 1; idle_do = 0; send_m(32'h0000_FFFF); wait_idle();
    idle_do = 1; send_m(32'h0000_0000); wait_idle();
    chk(rx_data[15:0] == 16'hFFFF, "R5 forced level looped back", rx_data, 32'hFFFF);
    force_do = 0; cycles(4); idle_do = 0; cycles(4);

    // R9 master drain on disable
    word_sel = 2'b00; clk_sel = 2'b11;
    send_m(32'h11); send_m(32'h22);
    en = 0;
    cycles(1);
    chk(tx_ready == 0, "R9 no accept while disabled", tx_ready, 0);
    wait_idle();
    chk(rx_data == 0 && busy == 0, "R9 cleared after drain", rx_data, 0);
    mrx = 0;
    en = 1; cycles(2);

    // R10 soft reset mid-word
    word_sel = 2'b10; clk_sel = 2'b00;
    send(32'hCAFE_F00D); send(32'h1234_5678);
    cycles(20);
    chk(busy == 1, "R10 word in progress", busy, 1);
    soft_rst = 1;
    cycles(1);
    chk(tx_ready == 0, "R8 ready low in soft reset", tx_ready, 0);
    soft_rst = 0;
    chk(busy == 0 && rx_data == 0, "R10 cleared", rx_data, 0);
    cycles(600);
    chk(busy == 0, "R10 held word discarded", busy, 0);

    // R6 synchronizer with a driven pattern
    loop = 0;
    for (int k = 0; k < 24; k++) begin di_drv = k[0] ^ k[2] ^ k[3]; cycles(1); end
    di_drv = 0;
    mrx = 0;

    // R7 slave mode
    slave = 1; cs_en = 1; cpol = 0; cpha = 0; word_sel = 2'b00; cycles(4);
    send(32'h96); expect_word(32'h3C, 0);
    slave_xfer(8, 32'h3C, 32'h96, 1); wait_idle();
    cpol = 1; cpha = 1; word_sel = 2'b01; sclk_in = 1; cycles(4);
    send(32'hBEEF); expect_word(32'h1357, 0);
    slave_xfer(16, 32'h1357, 32'hBEEF, 1); wait_idle();
    // R2 code 11 acts as 8 bits in slave mode
    cpol = 0; cpha = 0; word_sel = 2'b11; sclk_in = 0; cycles(4);
    send(32'hA5); expect_word(32'h81, 0);
    slave_xfer(8, 32'h81, 32'hA5, 1); wait_idle();
    chk(rx_data == 32'h0000_1381, "R2 slave code 11", rx_data, 32'h0000_1381);
    // chip select ignored
    cs_en = 0; word_sel = 2'b00; cycles(4);
    send(32'h77); expect_word(32'h44, 0);
    slave_xfer(8, 32'h44, 32'h77, 0); wait_idle();
    // chip select honoured and inactive: nothing moves
    cs_en = 1; cycles(4);
    send(32'h55);
    slave_xfer(8, 32'hFF, 32'h00, 0);
    cycles(20);
    chk(busy == 0, "R7 deselected slave idle", busy, 0);
    chk(rx_data == 32'h0000_1344, "R7 deselected slave no receive", rx_data, 32'h0000_1344);

    // R9 slave disable clears at once
    en = 0; cycles(1);
    chk(tx_ready == 0 && rx_data == 0, "R9 slave immediate clear", rx_data, 0);

    chk(exp_rx_q.size() == 0, "R12 all words received", exp_rx_q.size(), 0);
    finish_run();
  end
endmodule